// File: doc/BRIEF.md
# Fixed-function accelerator client shim

This block lets a task scheduler drive a fixed-function device (an encryption engine, an output port) that cannot switch context, with no host processor acting as a proxy. When the scheduler raises its task-available line, the shim reads a four-word task control block from the scheduler. If that block asks for it, the shim then forwards a run of configuration words to the device ahead of any data. Next it works through the data one word at a time: it fetches each word from memory, starts the device on it, waits for completion and writes the result to the destination buffer. Finally it tells the scheduler that the work is done, by releasing a waiting task, by creating a follow-on task, or both.

The task control block is indexed in word units. Word 0 holds the flags, word 1 the source word address, word 2 the destination word address and word 3 the length in words. Configuration words follow from word 4 upward. Every access to the scheduler or to memory is a valid/ready request. The device takes a one-cycle start pulse and answers with a one-cycle done pulse. Only one task is in progress at any time, and a task, once begun, always runs to its end.

Top module: `accel_task_shim`

## Requirements
- R1: Out of reset, and while idle with `task_irq` low, the shim raises no scheduler, memory, configuration or start request.
- R2: A task begins when `task_irq` is seen high while idle. The shim then reads task-block words 0, 1, 2 and 3 in that order, using scheduler op 0 (read) with the word number on `sch_idx`.
- R3: When flags bit 0 is set and the count in flags bits [4+CW-1:4] is nonzero, the shim reads task-block words 4 upward, one per configuration word. It writes each word to the device configuration port before any memory fetch takes place.
- R4: For each data word i, taken in ascending order, the shim reads memory at source+i, pulses `dev_start` with that word on `dev_din`, and writes `dev_dout` to memory at destination+i.
- R5: A length of zero skips fetch, device run and write-back completely, and the closing signalling still takes place.
- R6: After the data phase the shim issues scheduler op 1 (release a waiting task) if flags bit 1 is set, and then op 2 (create a follow-on task) if flags bit 2 is set. Both carry the destination address on `sch_wdata`.
- R7: `task_irq` is ignored while a task is in progress. Each task runs to completion before the next task-block read begins.
- R8: Once a scheduler, memory or configuration request is raised without ready, it stays raised and its fields stay unchanged until ready is seen.
- R9: `dev_start` is high for exactly one cycle, and it is not raised again until `dev_done` has answered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| task_irq | input | 1 | Task available from the scheduler |
| sch_valid | output | 1 | Scheduler request valid |
| sch_ready | input | 1 | Scheduler request accepted; read data valid in the same cycle |
| sch_op | output | 2 | 0 read task-block word, 1 release waiting task, 2 create task |
| sch_idx | output | CW+1 | Task-block word number for reads |
| sch_wdata | output | DW | Destination address sent with ops 1 and 2 |
| sch_rdata | input | DW | Task-block word returned |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request accepted; read data valid in the same cycle |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | AW | Word address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data |
| dev_cfg_valid | output | 1 | Configuration word valid |
| dev_cfg_ready | input | 1 | Configuration word accepted |
| dev_cfg_data | output | DW | Configuration word |
| dev_start | output | 1 | One-cycle start pulse |
| dev_din | output | DW | Input word for the device |
| dev_done | input | 1 | One-cycle completion pulse |
| dev_dout | input | DW | Result word, valid with `dev_done` |

## Verification
The hardest case to reach from the ports is a task-available line that is already high, or rises, while a sequence is still running, so that a careless design would restart or interleave. The bench queues tasks in bursts, which keeps `task_irq` high through the whole run of the earlier task, and checks every handshake against one ordered list of expected events built from the task blocks. Random ready and done latencies hold requests under back-pressure. Zero-length tasks and config-flag-with-zero-count tasks are forced in directly.

// File: rtl/accel_task_shim.sv
`timescale 1ns/1ps
module accel_task_shim #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int LW = 16,
  parameter int CW = 4,
  localparam int IW = CW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          task_irq,
  output logic          sch_valid,
  input  logic          sch_ready,
  output logic [1:0]    sch_op,
  output logic [IW-1:0] sch_idx,
  output logic [DW-1:0] sch_wdata,
  input  logic [DW-1:0] sch_rdata,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          dev_cfg_valid,
  input  logic          dev_cfg_ready,
  output logic [DW-1:0] dev_cfg_data,
  output logic          dev_start,
  output logic [DW-1:0] dev_din,
  input  logic          dev_done,
  input  logic [DW-1:0] dev_dout
);
  localparam logic [1:0] OP_RD = 2'd0, OP_SYNC = 2'd1, OP_NEW = 2'd2;

  typedef enum logic [2:0] {
    S_IDLE, S_READ_TCB, S_CONFIG, S_FETCH, S_RUN, S_WRITEBACK, S_SIGNAL
  } state_t;

  state_t        st;
  logic          ph;
  logic [1:0]    tcb_i;
  logic          f_cfg, f_sync, f_new;
  logic [CW-1:0] cfg_n, cfg_k;
  logic [AW-1:0] src, dst;
  logic [LW-1:0] len, idx;
  logic [DW-1:0] data_q;

  wire want_sync = f_sync && !ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;  ph <= 1'b0;  tcb_i <= '0;
      f_cfg <= 1'b0; f_sync <= 1'b0; f_new <= 1'b0;
      cfg_n <= '0;   cfg_k <= '0;
      src <= '0;     dst <= '0;  len <= '0;  idx <= '0;
      data_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (task_irq) begin
          st <= S_READ_TCB; tcb_i <= '0; idx <= '0; cfg_k <= '0; ph <= 1'b0;
        end
        S_READ_TCB: if (sch_ready) begin
          tcb_i <= tcb_i + 2'd1;
          case (tcb_i)
            2'd0: begin
              f_cfg <= sch_rdata[0]; f_sync <= sch_rdata[1]; f_new <= sch_rdata[2];
              cfg_n <= sch_rdata[4 +: CW];
            end
            2'd1: src <= sch_rdata[AW-1:0];
            2'd2: dst <= sch_rdata[AW-1:0];
            default: begin
              len <= sch_rdata[LW-1:0];
              if (f_cfg && cfg_n != '0)           st <= S_CONFIG;
              else if (sch_rdata[LW-1:0] != '0)   st <= S_FETCH;
              else                                st <= S_SIGNAL;
            end
          endcase
        end
        S_CONFIG: if (!ph) begin
          if (sch_ready) begin data_q <= sch_rdata; ph <= 1'b1; end
        end else if (dev_cfg_ready) begin
          ph <= 1'b0;
          cfg_k <= cfg_k + 1'b1;
          if (cfg_k == cfg_n - 1'b1) st <= (len != '0) ? S_FETCH : S_SIGNAL;
        end
        S_FETCH: if (mem_ready) begin
          data_q <= mem_rdata; st <= S_RUN; ph <= 1'b0;
        end
        S_RUN: if (!ph) ph <= 1'b1;
               else if (dev_done) begin data_q <= dev_dout; ph <= 1'b0; st <= S_WRITEBACK; end
        S_WRITEBACK: if (mem_ready) begin
          idx <= idx + 1'b1;
          st  <= (idx == len - 1'b1) ? S_SIGNAL : S_FETCH;
        end
        S_SIGNAL: if (want_sync) begin
          if (sch_ready) ph <= 1'b1;
        end else if (f_new) begin
          if (sch_ready) begin st <= S_IDLE; ph <= 1'b0; end
        end else begin
          st <= S_IDLE; ph <= 1'b0;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign sch_valid = (st == S_READ_TCB) || (st == S_CONFIG && !ph) ||
                     (st == S_SIGNAL && (want_sync || f_new));
  assign sch_op    = (st != S_SIGNAL) ? OP_RD : (want_sync ? OP_SYNC : OP_NEW);
  assign sch_idx   = (st == S_CONFIG) ? IW'(4) + IW'(cfg_k) : IW'(tcb_i);
  assign sch_wdata = DW'(dst);

  assign mem_valid = (st == S_FETCH) || (st == S_WRITEBACK);
  assign mem_we    = (st == S_WRITEBACK);
  assign mem_addr  = (mem_we ? dst : src) + AW'(idx);
  assign mem_wdata = data_q;

  assign dev_cfg_valid = (st == S_CONFIG) && ph;
  assign dev_cfg_data  = data_q;
  assign dev_start     = (st == S_RUN) && !ph;
  assign dev_din       = data_q;

  AST_SCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    sch_valid && !sch_ready |=> sch_valid && $stable(sch_op) && $stable(sch_idx) && $stable(sch_wdata)); // R8
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)); // R8
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    dev_cfg_valid && !dev_cfg_ready |=> dev_cfg_valid && $stable(dev_cfg_data)); // R8
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    dev_start |=> !dev_start); // R9
  AST_TCB_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) && task_irq |=> sch_valid && sch_op == OP_RD && sch_idx == '0); // R2
  AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_READ_TCB) && sch_ready && tcb_i == 2'd3 && sch_rdata[LW-1:0] == '0 && !(f_cfg && cfg_n != '0)
    |=> !mem_valid && !dev_start); // R5
endmodule

// File: tb/accel_task_shim_tb_top.sv
`timescale 1ns/1ps
module accel_task_shim_tb_top;
  localparam int AW = 16, DW = 32, LW = 16, CW = 4, IW = CW + 1;
  localparam int K_TCB = 0, K_CFG = 1, K_MRD = 2, K_GO = 3, K_MWR = 4, K_SYNC = 5, K_NEW = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic task_irq, sch_valid, sch_ready = 1'b0, mem_valid, mem_ready = 1'b0, mem_we;
  logic dev_cfg_valid, dev_cfg_ready = 1'b0, dev_start, dev_done = 1'b0;
  logic [1:0] sch_op;
  logic [IW-1:0] sch_idx;
  logic [DW-1:0] sch_wdata, sch_rdata, mem_wdata, mem_rdata, dev_cfg_data, dev_din, dev_dout;
  logic [AW-1:0] mem_addr;

  int nchk = 0, nfail = 0, started = 0, queued = 0, rp = 0, wp = 0, mem_ev = 0, ev_all = 0;
  logic [DW-1:0] tcb_mem [0:63][0:7];
  logic [DW-1:0] mem [0:255];
  int exp_k [0:4095];
  logic [DW-1:0] exp_a [0:4095], exp_d [0:4095];
  bit bump = 0, start_seen = 0, dev_busy = 0, prev_start = 0;
  int dev_cnt = 0;
  logic [DW-1:0] dev_res = '0;
  bit ps_v = 0, pm_v = 0;
  logic [1:0] ps_op; logic [IW-1:0] ps_idx; logic [DW-1:0] ps_wd, pm_wd; logic pm_we; logic [AW-1:0] pm_addr;

  assign task_irq = (started < queued);
  assign sch_rdata = tcb_mem[((sch_idx == 0) ? started : started - 1) & 63][sch_idx[2:0]];
  assign mem_rdata = mem[mem_addr[7:0]];
  assign dev_dout  = dev_res;

  accel_task_shim #(.AW(AW), .DW(DW), .LW(LW), .CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .task_irq(task_irq),
    .sch_valid(sch_valid), .sch_ready(sch_ready), .sch_op(sch_op), .sch_idx(sch_idx),
    .sch_wdata(sch_wdata), .sch_rdata(sch_rdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .dev_cfg_valid(dev_cfg_valid), .dev_cfg_ready(dev_cfg_ready), .dev_cfg_data(dev_cfg_data),
    .dev_start(dev_start), .dev_din(dev_din), .dev_done(dev_done), .dev_dout(dev_dout));

  function automatic logic [DW-1:0] dev_fn(logic [DW-1:0] x);
    return {x[12:0], x[31:13]} ^ 32'h6B2D_91C4;
  endfunction

  function automatic string tag(int k);
    case (k)
      K_TCB: return "R2"; K_CFG: return "R3"; K_SYNC: return "R6"; K_NEW: return "R6";
      default: return "R4";
    endcase
  endfunction

  task automatic fail(string r, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    nfail++;
    $display("FAIL %s %s: actual %h expected %h", r, what, act, exp);
  endtask

  task automatic push(int k, logic [DW-1:0] a, logic [DW-1:0] d);
    exp_k[wp] = k; exp_a[wp] = a; exp_d[wp] = d; wp++;
  endtask

  task automatic observe(int k, logic [DW-1:0] a, logic [DW-1:0] d);
    nchk++; ev_all++;
    if (rp >= wp) fail(tag(k), $sformatf("unexpected event kind %0d addr", k), a, '1);
    else begin
      if (exp_k[rp] != k) fail(tag(exp_k[rp]), "event kind", DW'(k), DW'(exp_k[rp]));
      else if (exp_a[rp] != a) fail(tag(k), "event address/index", a, exp_a[rp]);
      else if (exp_d[rp] != d) fail(tag(k), "event data", d, exp_d[rp]);
      rp++;
    end
  endtask

  // Monitor: samples at the falling edge, between driver updates and the next rising edge.
  initial forever begin
    @(negedge clk);
    if (rst_n) begin
      if (ps_v) begin
        nchk++;
        if (!sch_valid || sch_op != ps_op || sch_idx != ps_idx || sch_wdata != ps_wd)
          fail("R8", "scheduler request dropped or changed", {sch_valid, sch_op, sch_idx}, {1'b1, ps_op, ps_idx});
      end
      if (pm_v) begin
        nchk++;
        if (!mem_valid || mem_we != pm_we || mem_addr != pm_addr || mem_wdata != pm_wd)
          fail("R8", "memory request dropped or changed", DW'(mem_addr), DW'(pm_addr));
      end
      ps_v = sch_valid && !sch_ready; ps_op = sch_op; ps_idx = sch_idx; ps_wd = sch_wdata;
      pm_v = mem_valid && !mem_ready; pm_we = mem_we; pm_addr = mem_addr; pm_wd = mem_wdata;
      if (sch_valid && sch_ready) begin
        if (sch_op == 2'd0) begin
          observe(K_TCB, DW'(sch_idx), '0);
          if (sch_idx == 0) bump = 1;
        end else observe(sch_op == 2'd1 ? K_SYNC : K_NEW, '0, sch_wdata);
      end
      if (mem_valid && mem_ready) begin
        mem_ev++;
        if (mem_we) begin observe(K_MWR, DW'(mem_addr), mem_wdata); mem[mem_addr[7:0]] = mem_wdata; end
        else observe(K_MRD, DW'(mem_addr), '0);
      end
      if (dev_cfg_valid && dev_cfg_ready) observe(K_CFG, '0, dev_cfg_data);
      if (dev_start) begin
        nchk++;
        if (dev_busy || prev_start) fail("R9", "start while device busy", 1, 0);
        observe(K_GO, '0, dev_din);
        start_seen = 1; dev_res = dev_fn(dev_din);
      end
      prev_start = dev_start;
    end
  end

  // Driver: responders and device model, one ns after the rising edge.
  initial forever begin
    @(posedge clk); #1;
    if (bump) begin started++; bump = 0; end
    dev_done = 1'b0;
    if (start_seen) begin dev_busy = 1; dev_cnt = $urandom % 3; start_seen = 0; end
    else if (dev_busy) begin
      if (dev_cnt == 0) begin dev_done = 1'b1; dev_busy = 0; end
      else dev_cnt--;
    end
    sch_ready     = ($urandom % 3) != 0;
    mem_ready     = ($urandom % 4) != 0;
    dev_cfg_ready = ($urandom % 2) != 0;
  end

  task automatic queue_task(logic cfg, int ncfg, logic sync, logic create, int src, int dst, int len);
    int t = queued;
    tcb_mem[t][0] = DW'(cfg) | (DW'(sync) << 1) | (DW'(create) << 2) | (DW'(ncfg) << 4);
    tcb_mem[t][1] = DW'(src); tcb_mem[t][2] = DW'(dst); tcb_mem[t][3] = DW'(len);
    for (int k = 4; k < 8; k++) tcb_mem[t][k] = $urandom;
    for (int k = 0; k < 4; k++) push(K_TCB, DW'(k), '0);
    if (cfg) for (int k = 0; k < ncfg; k++) begin
      push(K_TCB, DW'(4 + k), '0); push(K_CFG, '0, tcb_mem[t][4 + k]);
    end
    for (int i = 0; i < len; i++) begin
      push(K_MRD, DW'(src + i), '0);
      push(K_GO, '0, mem[src + i]);
      push(K_MWR, DW'(dst + i), dev_fn(mem[src + i]));
    end
    if (sync)   push(K_SYNC, '0, DW'(dst));
    if (create) push(K_NEW, '0, DW'(dst));
    queued++;
  endtask

  task automatic wait_done(string r);
    int n = 0;
    while (!(rp == wp && started == queued) && n < 20000) begin @(posedge clk); n++; end
    repeat (6) @(posedge clk);
    nchk++;
    if (n >= 20000 || rp != wp) fail(r, "sequence did not complete (events consumed)", DW'(rp), DW'(wp));
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    #(4 * 190000);
    nfail++; $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int m0, e0;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) mem[i] = $urandom;
    repeat (3) @(posedge clk); #1;
    nchk++;
    if (sch_valid || mem_valid || dev_cfg_valid || dev_start)
      fail("R1", "request active in reset", {sch_valid, mem_valid, dev_cfg_valid, dev_start}, 0);
    rst_n = 1'b1;
    repeat (20) @(posedge clk);
    nchk++;
    if (ev_all != 0) fail("R1", "activity while idle without task", DW'(ev_all), 0);

    queue_task(0, 0, 1, 0, 10, 140, 3);  wait_done("R4");   // plain data path, release only
    queue_task(1, 2, 0, 1, 20, 150, 1);  wait_done("R3");   // config ahead of data, create
    m0 = mem_ev; e0 = ev_all;
    queue_task(0, 0, 1, 1, 30, 160, 0);  wait_done("R5");   // zero length still signals (R6 order)
    nchk++;
    if (mem_ev != m0) fail("R5", "memory traffic on zero-length task", DW'(mem_ev - m0), 0);
    nchk++;
    if (ev_all - e0 != 6) fail("R5", "event count on zero-length task", DW'(ev_all - e0), 6);
    queue_task(1, 0, 0, 0, 40, 170, 0);  wait_done("R3");   // config flag with zero count
    queue_task(1, 3, 1, 1, 50, 180, 5);                      // R7: second task queued while first runs
    queue_task(0, 0, 1, 0, 60, 200, 4);
    wait_done("R7");
    nchk++;
    if (started != queued) fail("R7", "tasks started vs queued", DW'(started), DW'(queued));

    while (queued < 60) begin
      int burst = 1 + $urandom % 3;
      for (int b = 0; b < burst && queued < 60; b++) begin
        int len = ($urandom % 5 == 0) ? 0 : 1 + $urandom % 6;
        int src = $urandom % (128 - len);
        int dst = 128 + $urandom % (128 - len);
        queue_task(1'($urandom), $urandom % 4, 1'($urandom), 1'($urandom), src, dst, len);
      end
      wait_done("R7");
    end
    repeat (20) @(posedge clk);
    nchk++;
    if (rp != wp) fail("R1", "events outstanding at end", DW'(rp), DW'(wp));
    summary();
  end
endmodule